// File: doc/BRIEF.md
# Interval Timer with Compare-Clear

This block is an 8-bit interval timer. A prescaler turns the system clock into a count strobe, and a 3-bit clock-select field picks the divide ratio. Each count strobe advances the counter by one. When the counter equals the compare value, the block raises a one-cycle interrupt pulse.

When the clear mode is on, that match also returns the counter to zero. The pulse then repeats every (N+1) count strobes, where N is the compare value. When the clear mode is off, the counter runs freely through its full range. The interrupt then fires once per wrap, each time the counter passes N.

Software sets the clock select, the compare value and the mode while the timer is stopped, and then sets the run bit. While the timer runs, the compare register cannot be written. Clearing the run bit holds the counter at zero and restarts the prescaler. Every register is clocked by the system clock, and the count strobe is a clock enable rather than a second clock.

Top module: `intv_timer`

## Requirements
- R1: Registers are selected by `bus_addr`: 0 is the clock select (bits 2:0), 1 is the compare value (bits 7:0), 2 is the control register (bit 0 run, bit 1 clear-on-match mode), and 3 is the counter, which is read-only. `bus_rdata` shows the selected register in the same cycle. Unused bits read as 0, and all registers read 0 after reset.
- R2: While run is 0, the counter holds 00H and the prescaler is held at its start. The counter reads 00H a few cycles after a stop.
- R3: With the clear mode set and the compare value N between 01H and FFH, a count strobe that finds the counter equal to N sets the counter to 00H. It also produces an interrupt one cycle later. The interrupts repeat every (N+1)·D system cycles.
- R4: Clock-select codes 0 to 7 give a count strobe every 1, 2, 4, 8, 16, 32, 64 and 256 system cycles (D).
- R5: With a compare value from 01H to FFH, the interrupt is high for exactly one system cycle per match.
- R6: A write to the compare register while run is 1 is ignored, and the interval stays as it was.
- R7: With the clear mode at 0, the counter wraps from FFH to 00H and is not cleared on a match. An interrupt still fires on each match, so after the first one, interrupts are 256·D cycles apart.
- R8: After run is set, the first interrupt comes (N+1)·D cycles after the write edge. This holds also when the timer was stopped part-way through an interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Interrupt pulse, one cycle wide per match |

## Verification
The assertions check several rules on every cycle:
- a match in clear mode zeroes the counter and raises the interrupt;
- the counter wraps in free-running mode;
- the counter stays at zero while stopped;
- the compare register is locked during a run;
- the interrupt lasts one cycle;
- prescaler strobes are never back to back at a divided rate.

Only the bench scenarios can show the exact interrupt cycles. The scoreboard checks them for several divide codes, both modes, a rejected compare write and a restart after a stop cut an interval short.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

  typedef enum logic [1:0] {
    REG_CKSEL = 2'd0,
    REG_CMP   = 2'd1,
    REG_CTRL  = 2'd2,
    REG_COUNT = 2'd3
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;

  // Divide exponent for a clock-select code: codes map to 2**code, and the
  // last code skips one step to reach a wider division.
  function automatic int div_shift(input int code, input int ncode);
    return (code == ncode - 1) ? code + 1 : code;
  endfunction

endpackage

// File: rtl/intv_prescaler.sv
module intv_prescaler
  import intv_timer_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int NCODE = 1 << SEL_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [NCODE-1:0] strobe;

  always_comb begin
    if (run) pre_d = pre_q + 1'b1;
    else     pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar i = 0; i < NCODE; i++) begin : g_strobe
    localparam int SH = div_shift(i, NCODE);
    if (SH == 0) begin : g_full
      assign strobe[i] = 1'b1;
    end else begin : g_div
      assign strobe[i] = &pre_q[SH-1:0];
    end
  end

  assign tick = run & strobe[sel];

  // R4: at any divided rate two strobes are never adjacent
  assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0 && $past(sel) == sel) |-> !$past(tick));

endmodule

// File: rtl/intv_counter.sv
module intv_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr_mode,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);

  logic [CNT_W-1:0] cnt_d;
  logic             irq_d;
  logic             match;
  logic             hit;

  assign match = (cnt_q == cmp);
  assign hit   = tick & match;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (match && clr_mode) cnt_d = '0;
      else                   cnt_d = cnt_q + 1'b1;
    end
    irq_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assert_clear_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && clr_mode) |=> (cnt_q == '0 && irq_q));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && cmp != '0) |=> !irq_q);

  assert_free_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr_mode && cnt_q == '1) |=> cnt_q == '0);

  assert_stopped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0);

endmodule

// File: rtl/intv_regs.sv
module intv_regs
  import intv_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [SEL_W-1:0]  cksel_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic              run_q,
  output logic              clr_q
);

  logic [SEL_W-1:0]  cksel_d;
  logic [DATA_W-1:0] cmp_d;
  logic              run_d;
  logic              clr_d;
  logic              unused_wbits;

  assign unused_wbits = ^wdata[DATA_W-1:SEL_W];

  always_comb begin
    cksel_d = cksel_q;
    cmp_d   = cmp_q;
    run_d   = run_q;
    clr_d   = clr_q;
    if (we) begin
      unique case (reg_addr_e'(addr))
        REG_CKSEL: cksel_d = wdata[SEL_W-1:0];
        REG_CMP:   if (!run_q) cmp_d = wdata;
        REG_CTRL: begin
          run_d = wdata[CTRL_RUN_BIT];
          clr_d = wdata[CTRL_CLR_BIT];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cksel_q <= '0;
      cmp_q   <= '0;
      run_q   <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      cksel_q <= cksel_d;
      cmp_q   <= cmp_d;
      run_q   <= run_d;
      clr_q   <= clr_d;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr))
      REG_CKSEL: rdata = {{(DATA_W-SEL_W){1'b0}}, cksel_q};
      REG_CMP:   rdata = cmp_q;
      REG_CTRL:  rdata = {{(DATA_W-2){1'b0}}, clr_q, run_q};
      REG_COUNT: rdata = cnt;
      default:   rdata = '0;
    endcase
  end

  assert_cmp_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && we && addr == REG_CMP) |=> $stable(cmp_q));

endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);

  localparam int NCODE = 1 << SEL_W;
  localparam int PRE_W = div_shift(NCODE - 1, NCODE);

  logic             rst_meta;
  logic             rst_sync_n;
  logic [SEL_W-1:0] cksel;
  logic [CNT_W-1:0] cmp;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic             clr_mode;
  logic             tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  intv_regs #(.DATA_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (bus_we),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .rdata   (bus_rdata),
    .cksel_q (cksel),
    .cmp_q   (cmp),
    .run_q   (run),
    .clr_q   (clr_mode)
  );

  intv_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (run),
    .sel   (cksel),
    .tick  (tick)
  );

  intv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .clr_mode (clr_mode),
    .tick     (tick),
    .cmp      (cmp),
    .cnt_q    (cnt),
    .irq_q    (irq)
  );

endmodule

// File: tb/intv_timer_test.sv
`timescale 1ns/100ps
module intv_timer_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;
  int c_wr     = 0;
  int exp_q[$];
  bit done     = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  intv_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
    c_wr = cyc;
  endtask

  task automatic rd(input logic [1:0] a, input string req, input int exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(req, int'(bus_rdata), exp);
  endtask

  function automatic int div_of(input int sel);
    return (sel == 7) ? 256 : (1 << sel);
  endfunction

  // Driver: configure, start, push expected interrupt cycles, then stop.
  task automatic run_case(input int sel, input int n, input bit clr, input int pulses,
                          input bit poke);
    int d, first, per, last;
    d = div_of(sel);
    wr(2'd0, 8'(sel));
    wr(2'd1, 8'(n));
    wr(2'd2, {6'd0, clr, 1'b0});
    wr(2'd2, {6'd0, clr, 1'b1});
    first = c_wr + (n + 1) * d;                 // R3, R4, R8
    per   = clr ? (n + 1) * d : 256 * d;        // R3 or R7
    for (int i = 0; i < pulses; i++) exp_q.push_back(first + i * per);
    last = first + (pulses - 1) * per;
    if (poke) begin
      wr(2'd1, 8'(n / 2));                      // R6: must be ignored
      rd(2'd1, "R6 compare locked", n);
    end
    while (cyc <= last) @(posedge clk);
    wr(2'd2, 8'd0);
    repeat (3) @(posedge clk);
    rd(2'd3, "R2 counter held at zero", 0);
    chk("R3 all expected pulses seen", exp_q.size(), 0);
  endtask

  // Monitor: each interrupt pops the scoreboard and compares its cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0 && cyc > exp_q[0]) begin
        chk("R3 missed interrupt", cyc, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (irq) begin
        if (exp_q.size() == 0) chk("R5 unexpected interrupt", cyc, -1);
        else chk("R3 interrupt cycle", cyc, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_checks++; n_errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'd0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(2'd0, "R1 reset cksel", 0);
    rd(2'd1, "R1 reset cmp", 0);
    rd(2'd2, "R1 reset ctrl", 0);
    rd(2'd3, "R1 reset count", 0);
    chk("R5 irq low after reset", int'(irq), 0);

    // R1 field masking
    wr(2'd0, 8'hFD);
    rd(2'd0, "R1 cksel bits", 5);
    wr(2'd2, 8'hFE);
    rd(2'd2, "R1 ctrl bits", 2);
    wr(2'd2, 8'h00);

    // R3/R4/R5 clear-on-match at several rates
    run_case(0, 5,   1'b1, 3, 1'b0);
    run_case(1, 3,   1'b1, 3, 1'b0);
    run_case(3, 1,   1'b1, 3, 1'b0);
    run_case(5, 2,   1'b1, 2, 1'b0);
    run_case(7, 2,   1'b1, 2, 1'b0);
    run_case(0, 255, 1'b1, 2, 1'b0);

    // R6 compare write during run ignored
    run_case(1, 7, 1'b1, 3, 1'b1);

    // R7 free-running wrap
    run_case(0, 5, 1'b0, 2, 1'b0);
    run_case(2, 9, 1'b0, 2, 1'b0);

    // R8 stop mid-interval, then full first interval
    wr(2'd0, 8'd2);
    wr(2'd1, 8'd10);
    wr(2'd2, 8'h03);
    repeat (20) @(posedge clk);
    wr(2'd2, 8'h02);
    repeat (3) @(posedge clk);
    rd(2'd3, "R2 counter zero after stop", 0);
    chk("R8 no interrupt before restart", exp_q.size(), 0);
    run_case(2, 10, 1'b1, 2, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule